// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR flash. It takes one bus write per cycle (address, data byte and a bus-width select) and follows the unlock-prefixed command sequences. From them it raises single-cycle operation requests for an external program/erase sequencer: program (with address and data), chip erase, sector erase (with a mask of sectors), erase suspend and erase resume. It also keeps the read mode that the array read path uses: normal array, autoselect, query table or hidden ROM region.

The two unlock writes are data AAh followed by data 55h. Their addresses depend on the bus width. Only address bits 10..0 take part in command matching. Beyond plain program and erase, the decoder handles several further modes:
- a fast mode with two-write programming;
- a sector-erase queue that collects sectors until a quiet window expires;
- a temporary-unprotect switch;
- entry to and exit from the hidden ROM region.

While the sequencer reports busy, only suspend and resume are accepted.

Top module: `fcd_top`

## Requirements
- R1: The command address is 555h with `dw_mode`=1 and AAAh with `dw_mode`=0. The second unlock address is 2AAh with `dw_mode`=1 and 555h with `dw_mode`=0. Only `wr_addr[10:0]` is compared, so upper address bits do not matter. An unlock write at the other width's addresses is ignored.
- R2: Data F0h returns `read_mode` to array (code 0). This works as a single write at any address, or after the unlock pair with F0h at the command address. It has no effect while in the hidden ROM region.
- R3: The unlock pair followed by 90h at the command address sets `read_mode` to autoselect (code 1).
- R4: The unlock pair followed by A0h arms programming. The next write produces a one-cycle `prog_req` one clock later, carrying that write's address on `prog_addr` and its data on `prog_data`. At most one request output is high in any cycle.
- R5: The unlock pair, 80h, the unlock pair again, then 10h at the command address produces a one-cycle `chip_erase_req`.
- R6: If the last write of the R5 sequence is instead 30h, it adds sector `wr_addr[19:16]` to `sect_mask` and opens a quiet window. Each further 30h write adds another sector and restarts the window. When `ERASE_TMO` clocks pass with no write, `sect_erase_req` pulses for one cycle with the accumulated mask. The mask then clears.
- R7: Any write other than 30h during the quiet window cancels the queued erase: no request is raised and `sect_mask` returns to 0.
- R8: While `seq_busy`=1, B0h at any address produces a one-cycle `suspend_req`. Once suspended, 30h at any address produces a one-cycle `resume_req`.
- R9: While `seq_busy`=1, every write other than suspend/resume is ignored. No mode changes and no request is raised.
- R10: The unlock pair plus 20h sets `fast_mode`. In fast mode, A0h at any address followed by an address/data write programs. A write of 90h followed by F0h or 00h clears `fast_mode`.
- R11: The unlock pair plus E0h, followed by data 01h, sets `unprot_en`. Following it with data 00h clears `unprot_en`.
- R12: A single write of 98h at address 55h (`dw_mode`=1) or AAh (`dw_mode`=0) sets `read_mode` to query (code 2).
- R13: The unlock pair plus 88h sets `read_mode` to hidden (code 3). In that mode, the unlock pair plus A0h programs with `prog_hidden`=1. The unlock pair plus 90h followed by 00h returns `read_mode` to array.
- R14: A write that does not fit the next step of any sequence drops the partial sequence and leaves `read_mode` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | A bus write is present this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| dw_mode | input | 1 | 1 = double-word bus, 0 = word bus |
| seq_busy | input | 1 | Program/erase sequencer is running |
| prog_req | output | 1 | Program request pulse |
| prog_addr | output | ADDR_W | Program address |
| prog_data | output | 8 | Program data |
| prog_hidden | output | 1 | Program targets the hidden ROM region |
| chip_erase_req | output | 1 | Chip erase request pulse |
| sect_erase_req | output | 1 | Sector erase request pulse |
| sect_mask | output | 2**SECT_BITS | Sectors selected for erase |
| suspend_req | output | 1 | Erase suspend pulse |
| resume_req | output | 1 | Erase resume pulse |
| read_mode | output | 2 | 0 array, 1 autoselect, 2 query, 3 hidden |
| fast_mode | output | 1 | Fast programming mode active |
| unprot_en | output | 1 | Temporary unprotection enabled |

## Verification
Mode entry is tried with correct unlock pairs in both widths, with the other width's addresses, and with upper address bits set. These cases show whether matching uses the right address set and only the low eleven bits. Broken sequences and F0h inside the hidden region show whether a partial sequence is dropped without disturbing the current mode. Sector erase is tried with three sectors, with the exact expiry cycle measured, and again with a cancelling command. Together these separate restart of the window, accumulation of the mask, and the abort path. Busy is held during a full mode-entry sequence to show that it is blocked while suspend and resume still get through.

// File: rtl/fcd_pkg.sv
// Shared codes for the flash command decoder.
// Assumes 8-bit command bytes and an 11-bit command address field.
package fcd_pkg;
    typedef enum logic [1:0] {
        RM_ARRAY   = 2'd0,
        RM_AUTOSEL = 2'd1,
        RM_QUERY   = 2'd2,
        RM_HIDDEN  = 2'd3
    } rd_mode_t;

    typedef enum logic [3:0] {
        S_IDLE, S_UNL1, S_UNL2, S_ER1, S_ER2, S_ER3,
        S_PGM, S_UNP, S_HEXIT, S_FEXIT
    } seq_st_t;

    localparam int unsigned CMD_ADDR_W = 11;
    localparam logic [7:0] D_UNL1    = 8'hAA;
    localparam logic [7:0] D_UNL2    = 8'h55;
    localparam logic [7:0] D_RESET   = 8'hF0;
    localparam logic [7:0] D_AUTOSEL = 8'h90;
    localparam logic [7:0] D_PROG    = 8'hA0;
    localparam logic [7:0] D_ERASE   = 8'h80;
    localparam logic [7:0] D_CHIP    = 8'h10;
    localparam logic [7:0] D_SECT    = 8'h30;
    localparam logic [7:0] D_SUSP    = 8'hB0;
    localparam logic [7:0] D_FAST    = 8'h20;
    localparam logic [7:0] D_UNPROT  = 8'hE0;
    localparam logic [7:0] D_QUERY   = 8'h98;
    localparam logic [7:0] D_HIDDEN  = 8'h88;
endpackage

// File: rtl/fcd_addr_match.sv
// Compares the low command address field against the unlock and query
// addresses of the selected bus width. Purely combinational.
module fcd_addr_match
    import fcd_pkg::*;
(
    input  logic [CMD_ADDR_W-1:0] addr_lo,
    input  logic                  dw_mode,
    output logic                  at_cmd,
    output logic                  at_unl2,
    output logic                  at_query
);
    localparam logic [CMD_ADDR_W-1:0] DW_CMD  = 11'h555;
    localparam logic [CMD_ADDR_W-1:0] DW_UNL2 = 11'h2AA;
    localparam logic [CMD_ADDR_W-1:0] DW_QRY  = 11'h055;
    localparam logic [CMD_ADDR_W-1:0] W_CMD   = 11'hAAA & 11'h7FF;
    localparam logic [CMD_ADDR_W-1:0] W_UNL2  = 11'h555;
    localparam logic [CMD_ADDR_W-1:0] W_QRY   = 11'h0AA;

    // Select the width-dependent address set and compare.
    always_comb begin
        at_cmd   = addr_lo == (dw_mode ? DW_CMD  : W_CMD);
        at_unl2  = addr_lo == (dw_mode ? DW_UNL2 : W_UNL2);
        at_query = addr_lo == (dw_mode ? DW_QRY  : W_QRY);
    end
endmodule

// File: rtl/fcd_erase_queue.sv
// Collects sectors for a multi-sector erase and issues the request once
// TMO clocks pass without a new sector. Assumes add and abort are never
// high together and that abort only arrives while the window is open.
module fcd_erase_queue #(
    parameter int unsigned SECT_BITS = 4,
    parameter int unsigned TMO       = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    add,
    input  logic                    abort,
    input  logic [SECT_BITS-1:0]    sect_idx,
    output logic                    open,
    output logic                    req,
    output logic [2**SECT_BITS-1:0] mask
);
    localparam int unsigned NSECT = 2**SECT_BITS;
    localparam int unsigned CNT_W = $clog2(TMO + 1);

    logic [CNT_W-1:0] cnt;

    // Window counter and request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open <= 1'b0;
            req  <= 1'b0;
            cnt  <= '0;
        end else begin
            req <= 1'b0;
            if (abort) begin
                open <= 1'b0;
            end else if (add) begin
                open <= 1'b1;
                cnt  <= CNT_W'(TMO - 1);
            end else if (open) begin
                if (cnt == '0) begin
                    req  <= 1'b1;
                    open <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // One selection flag per sector.
    for (genvar g = 0; g < NSECT; g++) begin : g_sect
        always_ff @(posedge clk) begin
            if (!rst_n || abort || req)
                mask[g] <= 1'b0;
            else if (add && sect_idx == SECT_BITS'(g))
                mask[g] <= 1'b1;
        end
    end

    p_req_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> mask != '0);
    p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!open && mask == '0 && !req));
endmodule

// File: rtl/fcd_top.sv
// Command sequence decoder for a parallel NOR flash. Follows unlock-prefixed
// write sequences, raises one-cycle operation requests one clock after the
// deciding write, and holds the read mode. Assumes at most one write per cycle.
module fcd_top
    import fcd_pkg::*;
#(
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned SECT_BITS = 4,
    parameter int unsigned ERASE_TMO = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_valid,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [7:0]              wr_data,
    input  logic                    dw_mode,
    input  logic                    seq_busy,
    output logic                    prog_req,
    output logic [ADDR_W-1:0]       prog_addr,
    output logic [7:0]              prog_data,
    output logic                    prog_hidden,
    output logic                    chip_erase_req,
    output logic                    sect_erase_req,
    output logic [2**SECT_BITS-1:0] sect_mask,
    output logic                    suspend_req,
    output logic                    resume_req,
    output logic [1:0]              read_mode,
    output logic                    fast_mode,
    output logic                    unprot_en
);
    seq_st_t  st, st_n;
    rd_mode_t mode, mode_n;
    logic fast_n, unp_n, susp, susp_n;
    logic prog_n, chip_n, sus_n, res_n, q_add, q_abort, q_open, hid;
    logic at_cmd, at_unl2, at_query;

    fcd_addr_match u_match (
        .addr_lo (wr_addr[CMD_ADDR_W-1:0]),
        .dw_mode (dw_mode),
        .at_cmd  (at_cmd),
        .at_unl2 (at_unl2),
        .at_query(at_query)
    );

    fcd_erase_queue #(.SECT_BITS(SECT_BITS), .TMO(ERASE_TMO)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .add     (q_add),
        .abort   (q_abort),
        .sect_idx(wr_addr[ADDR_W-1 -: SECT_BITS]),
        .open    (q_open),
        .req     (sect_erase_req),
        .mask    (sect_mask)
    );

    // Next-state and request decode for one incoming write.
    always_comb begin
        st_n = st;  mode_n = mode;  fast_n = fast_mode;
        unp_n = unprot_en;  susp_n = susp;
        prog_n = 1'b0;  chip_n = 1'b0;  sus_n = 1'b0;  res_n = 1'b0;
        q_add = 1'b0;  q_abort = 1'b0;
        hid = (mode == RM_HIDDEN);
        if (wr_valid) begin
            if (seq_busy) begin
                if (!susp && wr_data == D_SUSP) begin
                    sus_n = 1'b1;  susp_n = 1'b1;
                end else if (susp && wr_data == D_SECT) begin
                    res_n = 1'b1;  susp_n = 1'b0;
                end
            end else if (susp && st == S_IDLE && wr_data == D_SECT) begin
                res_n = 1'b1;  susp_n = 1'b0;
            end else begin
                unique case (st)
                    S_IDLE: begin
                        if (q_open) begin
                            if (wr_data == D_SECT) q_add = 1'b1;
                            else                   q_abort = 1'b1;
                        end else if (fast_mode && wr_data == D_PROG) st_n = S_PGM;
                        else if (fast_mode && wr_data == D_AUTOSEL) st_n = S_FEXIT;
                        else if (wr_data == D_RESET) begin
                            if (!hid) mode_n = RM_ARRAY;
                        end else if (wr_data == D_QUERY && at_query && !hid)
                            mode_n = RM_QUERY;
                        else if (wr_data == D_UNL1 && at_cmd) st_n = S_UNL1;
                    end
                    S_UNL1: st_n = (wr_data == D_UNL2 && at_unl2) ? S_UNL2 : S_IDLE;
                    S_UNL2: begin
                        st_n = S_IDLE;
                        if (at_cmd) begin
                            case (wr_data)
                                D_RESET:   if (!hid) mode_n = RM_ARRAY;
                                D_AUTOSEL: if (hid) st_n = S_HEXIT;
                                           else     mode_n = RM_AUTOSEL;
                                D_PROG:    st_n = S_PGM;
                                D_ERASE:   st_n = S_ER1;
                                D_FAST:    fast_n = 1'b1;
                                D_UNPROT:  st_n = S_UNP;
                                D_HIDDEN:  mode_n = RM_HIDDEN;
                                default:   ;
                            endcase
                        end
                    end
                    S_ER1: st_n = (wr_data == D_UNL1 && at_cmd)  ? S_ER2 : S_IDLE;
                    S_ER2: st_n = (wr_data == D_UNL2 && at_unl2) ? S_ER3 : S_IDLE;
                    S_ER3: begin
                        st_n = S_IDLE;
                        if (wr_data == D_CHIP && at_cmd) chip_n = 1'b1;
                        else if (wr_data == D_SECT)      q_add  = 1'b1;
                    end
                    S_PGM: begin
                        st_n = S_IDLE;  prog_n = 1'b1;
                    end
                    S_UNP: begin
                        st_n = S_IDLE;
                        if (wr_data == 8'h01)      unp_n = 1'b1;
                        else if (wr_data == 8'h00) unp_n = 1'b0;
                    end
                    S_HEXIT: begin
                        st_n = S_IDLE;
                        if (wr_data == 8'h00) mode_n = RM_ARRAY;
                    end
                    S_FEXIT: begin
                        st_n = S_IDLE;
                        if (wr_data == D_RESET || wr_data == 8'h00) fast_n = 1'b0;
                    end
                    default: st_n = S_IDLE;
                endcase
            end
        end
    end

    // State, mode and request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;  mode <= RM_ARRAY;  fast_mode <= 1'b0;
            unprot_en <= 1'b0;  susp <= 1'b0;
            prog_req <= 1'b0;  chip_erase_req <= 1'b0;
            suspend_req <= 1'b0;  resume_req <= 1'b0;
            prog_addr <= '0;  prog_data <= '0;  prog_hidden <= 1'b0;
        end else begin
            st <= st_n;  mode <= mode_n;  fast_mode <= fast_n;
            unprot_en <= unp_n;  susp <= susp_n;
            prog_req <= prog_n;  chip_erase_req <= chip_n;
            suspend_req <= sus_n;  resume_req <= res_n;
            if (prog_n) begin
                prog_addr   <= wr_addr;
                prog_data   <= wr_data;
                prog_hidden <= hid;
            end
        end
    end

    assign read_mode = mode;

    p_req_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, chip_erase_req, sect_erase_req, suspend_req, resume_req}));
    p_prog_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> $past(wr_valid && !seq_busy));
    p_suspend_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |-> $past(seq_busy && wr_valid && wr_data == D_SUSP));
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && wr_valid && wr_data != D_SUSP && wr_data != D_SECT)
        |=> ($stable(read_mode) && $stable(fast_mode) && $stable(unprot_en)
             && !prog_req && !chip_erase_req));
    p_fast_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fast_mode) |-> $past(wr_valid && (wr_data == D_RESET || wr_data == 8'h00)));
endmodule

// File: tb/sim_fcd_top.sv
`timescale 1ns/1ps
module sim_fcd_top;
    localparam int AW  = 20;
    localparam int TMO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic dw_mode = 1'b1;
    logic seq_busy = 1'b0;
    logic prog_req, prog_hidden, chip_erase_req, sect_erase_req;
    logic suspend_req, resume_req, fast_mode, unprot_en;
    logic [AW-1:0] prog_addr;
    logic [7:0] prog_data;
    logic [15:0] sect_mask;
    logic [1:0] read_mode;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fcd_top #(.ADDR_W(AW), .SECT_BITS(4), .ERASE_TMO(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .dw_mode(dw_mode), .seq_busy(seq_busy),
        .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
        .prog_hidden(prog_hidden), .chip_erase_req(chip_erase_req),
        .sect_erase_req(sect_erase_req), .sect_mask(sect_mask),
        .suspend_req(suspend_req), .resume_req(resume_req),
        .read_mode(read_mode), .fast_mode(fast_mode), .unprot_en(unprot_en)
    );

    // {dw_mode, address, data, expected read_mode after the write}
    localparam int NV = 37;
    localparam logic [30:0] VEC [NV] = '{
        {1'b1, 20'h00555, 8'hAA, 2'd0}, {1'b1, 20'h002AA, 8'h55, 2'd0},
        {1'b1, 20'h00555, 8'h90, 2'd1}, {1'b1, 20'h00123, 8'hF0, 2'd0},
        {1'b1, 20'h00055, 8'h98, 2'd2}, {1'b1, 20'h00000, 8'hF0, 2'd0},
        {1'b0, 20'h000AA, 8'h98, 2'd2}, {1'b0, 20'h00000, 8'hF0, 2'd0},
        {1'b0, 20'h00AAA, 8'hAA, 2'd0}, {1'b0, 20'h00555, 8'h55, 2'd0},
        {1'b0, 20'h00AAA, 8'h90, 2'd1}, {1'b0, 20'h00AAA, 8'hAA, 2'd1},
        {1'b0, 20'h00555, 8'h55, 2'd1}, {1'b0, 20'h00AAA, 8'hF0, 2'd0},
        {1'b1, 20'h00555, 8'h90, 2'd0}, {1'b0, 20'h00555, 8'hAA, 2'd0},
        {1'b0, 20'h00555, 8'h55, 2'd0}, {1'b0, 20'h00AAA, 8'h90, 2'd0},
        {1'b1, 20'h00555, 8'hAA, 2'd0}, {1'b1, 20'h002AA, 8'h55, 2'd0},
        {1'b1, 20'h00555, 8'h90, 2'd1}, {1'b1, 20'h00555, 8'hAA, 2'd1},
        {1'b1, 20'h00123, 8'h55, 2'd1}, {1'b1, 20'h00555, 8'h90, 2'd1},
        {1'b1, 20'h00555, 8'hAA, 2'd1}, {1'b1, 20'h002AA, 8'h55, 2'd1},
        {1'b1, 20'h00555, 8'h88, 2'd3}, {1'b1, 20'h00000, 8'hF0, 2'd3},
        {1'b1, 20'h00055, 8'h98, 2'd3}, {1'b1, 20'h00555, 8'hAA, 2'd3},
        {1'b1, 20'h002AA, 8'h55, 2'd3}, {1'b1, 20'h00555, 8'h90, 2'd3},
        {1'b1, 20'h00000, 8'h00, 2'd0}, {1'b1, 20'hF8555, 8'hAA, 2'd0},
        {1'b1, 20'h7A2AA, 8'h55, 2'd0}, {1'b1, 20'h3F555, 8'h90, 2'd1},
        {1'b1, 20'h00000, 8'hF0, 2'd0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One write: driven at a falling edge, taken at the next rising edge,
    // returns at the following falling edge where its results are visible.
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;  wr_addr = a;  wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic unlock();
        wr(20'h00555, 8'hAA);
        wr(20'h002AA, 8'h55);
    endtask

    initial begin
        #(5ns * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        // Reset state
        check("reset read_mode", 32'(read_mode), 0);
        check("reset requests", 32'({prog_req, chip_erase_req, sect_erase_req,
              suspend_req, resume_req, fast_mode, unprot_en}), 0);
        check("reset sect_mask", 32'(sect_mask), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Mode table: R1 R2 R3 R12 R13 R14
        for (int i = 0; i < NV; i++) begin
            dw_mode = VEC[i][30];
            wr(VEC[i][29:10], VEC[i][9:2]);
            check($sformatf("R1 R2 R3 R12 R13 R14 mode row %0d", i),
                  32'(read_mode), 32'(VEC[i][1:0]));
        end
        dw_mode = 1'b1;

        // R4 program
        unlock();  wr(20'h00555, 8'hA0);  wr(20'h12345, 8'h5A);
        check("R4 prog_req", 32'(prog_req), 1);
        check("R4 prog_addr", 32'(prog_addr), 32'h12345);
        check("R4 prog_data", 32'(prog_data), 32'h5A);
        check("R4 prog_hidden", 32'(prog_hidden), 0);
        @(negedge clk);
        check("R4 single pulse", 32'(prog_req), 0);

        // R5 chip erase
        unlock();  wr(20'h00555, 8'h80);  unlock();  wr(20'h00555, 8'h10);
        check("R5 chip_erase_req", 32'(chip_erase_req), 1);

        // R6 queued sector erase with exact expiry
        unlock();  wr(20'h00555, 8'h80);  unlock();  wr(20'h20000, 8'h30);
        repeat (5) @(negedge clk);
        wr(20'h50000, 8'h30);
        wr(20'hF0123, 8'h30);
        check("R6 mask accumulate", 32'(sect_mask), 32'h8024);
        seen = 0;
        for (int k = 1; k <= TMO + 3; k++) begin
            @(negedge clk);
            if (sect_erase_req && seen == 0) begin
                seen = k;
                check("R6 mask at request", 32'(sect_mask), 32'h8024);
            end
        end
        check("R6 expiry cycle", seen, TMO);
        check("R6 mask cleared", 32'(sect_mask), 0);

        // R7 abort of queued erase
        unlock();  wr(20'h00555, 8'h80);  unlock();  wr(20'h30000, 8'h30);
        wr(20'h00555, 8'h90);
        seen = 0;
        for (int k = 1; k <= TMO + 3; k++) begin
            @(negedge clk);
            if (sect_erase_req) seen = 1;
        end
        check("R7 no erase after abort", seen, 0);
        check("R7 mask cleared", 32'(sect_mask), 0);
        check("R7 abort write consumed", 32'(read_mode), 0);

        // R8 and R9 while busy
        seq_busy = 1'b1;
        unlock();  wr(20'h00555, 8'h90);
        check("R9 busy blocks autoselect", 32'(read_mode), 0);
        unlock();  wr(20'h00555, 8'h20);
        check("R9 busy blocks fast mode", 32'(fast_mode), 0);
        wr(20'h0ABCD, 8'hB0);
        check("R8 suspend_req", 32'(suspend_req), 1);
        wr(20'h01234, 8'h30);
        check("R8 resume_req", 32'(resume_req), 1);
        seq_busy = 1'b0;
        wr(20'h00555, 8'h90);
        check("R9 no sequence survived busy", 32'(read_mode), 0);

        // R10 fast mode
        unlock();  wr(20'h00555, 8'h20);
        check("R10 fast set", 32'(fast_mode), 1);
        wr(20'h00000, 8'hA0);  wr(20'h0BEEF, 8'hC3);
        check("R10 fast prog_req", 32'(prog_req), 1);
        check("R10 fast prog_addr", 32'(prog_addr), 32'h0BEEF);
        check("R10 fast prog_data", 32'(prog_data), 32'hC3);
        wr(20'h00000, 8'h90);  wr(20'h00000, 8'h00);
        check("R10 fast exit 00", 32'(fast_mode), 0);
        unlock();  wr(20'h00555, 8'h20);
        wr(20'h00777, 8'h90);  wr(20'h00777, 8'hF0);
        check("R10 fast exit F0", 32'(fast_mode), 0);

        // R11 temporary unprotect
        unlock();  wr(20'h00555, 8'hE0);  wr(20'h00000, 8'h01);
        check("R11 unprot on", 32'(unprot_en), 1);
        unlock();  wr(20'h00555, 8'hE0);  wr(20'h00000, 8'h00);
        check("R11 unprot off", 32'(unprot_en), 0);

        // R13 hidden-region program and exit
        unlock();  wr(20'h00555, 8'h88);
        unlock();  wr(20'h00555, 8'hA0);  wr(20'h00040, 8'h77);
        check("R13 hidden prog_req", 32'(prog_req), 1);
        check("R13 prog_hidden", 32'(prog_hidden), 1);
        unlock();  wr(20'h00555, 8'h90);  wr(20'h00000, 8'h00);
        check("R13 hidden exit", 32'(read_mode), 0);

        // Reset returns to the initial state
        unlock();  wr(20'h00555, 8'h90);
        @(negedge clk);  rst_n = 1'b0;
        @(negedge clk);  rst_n = 1'b1;
        check("reset clears mode", 32'(read_mode), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule